// File: doc/BRIEF.md
# Five-Phase Multicycle Processor Core

This block is a small 32-bit processor core that does not overlap instructions. Each instruction passes through five phases, one clock each: fetch, decode with operand read, execute, memory, and write-back. The core has one word-addressed memory port that it shares between instruction fetch and data loads. The port has an address bus, a read data input, a write data output and a write strobe. A program counter, an instruction register, a general register file, an ALU and two adders make up the datapath. One adder makes the next sequential address and the other makes the branch target.

The core decodes four operations: register add, register subtract, load word and branch-if-not-equal. Any other encoding retires without side effects and only moves the program counter on. The current phase and a write-back port are brought out so that an observer can follow every retired register write.

Top module: `mc_core`

## Requirements
- R1: While reset is held and just after it is released, the phase output is 0 (fetch), the program counter is 0 and the address bus shows 0.
- R2: The phase output steps through 0,1,2,3,4 (fetch, decode, execute, memory, write-back) and then back to 0, so every instruction takes exactly five clocks.
- R3: During fetch the address bus carries the program counter, and the word returned on the read data input becomes the instruction. The write strobe is never asserted.
- R4: An instruction with op[31:26]=000000 and func[5:0]=010000 writes rs+rt (rs at [25:21], rt at [20:16]) into rd[15:11]. The shift field [10:6] has no effect.
- R5: An instruction with op=000000 and func=010010 writes rs−rt, modulo 2^32, into rd.
- R6: An instruction with op=100101 puts (rs + sign-extended imm[15:0]) modulo 2^AW on the address bus during the memory phase and writes the returned word into rt.
- R7: An instruction with op=000101 sets the next PC to PC+1+sign-extended imm when rs≠rt, and to PC+1 otherwise. Negative offsets jump backwards.
- R8: Any other op, or op=000000 with any other func, writes no register and sets the next PC to PC+1.
- R9: The register write port (wb_we, wb_reg, wb_data) is active only in the write-back phase. The program counter changes only on the edge that ends write-back.
- R10: All 32 general registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | AW | Word address for fetch or load |
| mem_rdata | input | XLEN | Word returned by memory for the current address |
| mem_wdata | output | XLEN | Write data (rt operand) |
| mem_we | output | 1 | Write strobe, held low |
| phase | output | 3 | Current phase, 0 fetch to 4 write-back |
| wb_we | output | 1 | A register is written at the end of this cycle |
| wb_reg | output | 5 | Destination register index |
| wb_data | output | XLEN | Value being written |

## Verification
The bench builds the core with XLEN=32, 32 registers and AW=10, which gives a 1024-word memory. A load address made from a random register plus an offset can therefore land anywhere, including in the program itself. That wraparound lets data loads read code words and lets sums that overflow 32 bits appear on the address bus. A directed countdown loop drives a backward branch and the taken and not-taken paths of the same instruction. A random program then mixes register arithmetic, loads, forward branches and illegal encodings, and every retirement is compared with a reference model in the bench.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    PH_FETCH = 3'd0, PH_DEC = 3'd1, PH_EXE = 3'd2, PH_MEM = 3'd3, PH_WB = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_LW, K_BNE
  } kind_e;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100101;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] FN_ADD   = 6'b010000;
  localparam logic [5:0] FN_SUB   = 6'b010010;

  function automatic kind_e classify(input logic [31:0] word);
    kind_e k;
    k = K_NOP;
    unique case (word[31:26])
      OP_RTYPE: begin
        if (word[5:0] == FN_ADD)      k = K_ADD;
        else if (word[5:0] == FN_SUB) k = K_SUB;
      end
      OP_LOAD: k = K_LW;
      OP_BNE:  k = K_BNE;
      default: k = K_NOP;
    endcase
    return k;
  endfunction

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] arith(input kind_e k, input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b, input logic [XLEN-1:0] imm);
    logic [XLEN-1:0] r;
    unique case (k)
      K_ADD:   r = a + b;
      K_SUB:   r = a - b;
      K_LW:    r = a + imm;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mc_phase.sv
module mc_phase
  import mc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_FETCH;
    else ph <= (ph == PH_WB) ? PH_FETCH : phase_e'(ph + 3'd1);
  end

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_WB) |=> (ph == phase_e'($past(ph) + 3'd1)));
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WB) |=> (ph == PH_FETCH));
  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PH_WB);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   ra1,
  input  logic [RW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int AW = 10
) (
  input  kind_e           kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  input  logic [AW-1:0]   pc,
  output logic [XLEN-1:0] result,
  output logic            differ,
  output logic [AW-1:0]   pc_inc,
  output logic [AW-1:0]   pc_tgt
);
  logic [XLEN-1:0] tgt_full;
  assign result   = arith(kind, a, b, imm);
  assign differ   = (a != b);
  assign pc_inc   = pc + AW'(1);
  assign tgt_full = XLEN'(pc_inc) + imm;
  assign pc_tgt   = tgt_full[AW-1:0];
  logic unused_hi;
  assign unused_hi = ^tgt_full[XLEN-1:AW];
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int AW   = 10,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   mem_addr,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  output logic [2:0]      phase,
  output logic            wb_we,
  output logic [RW-1:0]   wb_reg,
  output logic [XLEN-1:0] wb_data
);
  phase_e          ph;
  logic [AW-1:0]   pc;
  logic [XLEN-1:0] ir, a_q, b_q, imm_q, alu_q, mdr_q;
  logic [AW-1:0]   inc_q, tgt_q;
  logic            take_q;
  logic [XLEN-1:0] rs_val, rt_val, alu_res;
  logic            differ;
  logic [AW-1:0]   pc_inc, pc_tgt;
  kind_e           kind;

  // named internal events
  logic fetch_ev, wb_ev, pc_upd;

  assign kind     = classify(ir);
  assign fetch_ev = (ph == PH_FETCH);
  assign wb_ev    = (ph == PH_WB);
  assign pc_upd   = wb_ev;

  mc_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph));

  mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(ir[21 +: RW]), .ra2(ir[16 +: RW]),
    .rd1(rs_val), .rd2(rt_val),
    .we(wb_we), .wa(wb_reg), .wd(wb_data)
  );

  mc_alu #(.AW(AW)) u_alu (
    .kind(kind), .a(a_q), .b(b_q), .imm(imm_q), .pc(pc),
    .result(alu_res), .differ(differ), .pc_inc(pc_inc), .pc_tgt(pc_tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; ir <= '0; a_q <= '0; b_q <= '0; imm_q <= '0;
      alu_q <= '0; mdr_q <= '0; inc_q <= '0; tgt_q <= '0; take_q <= 1'b0;
    end else begin
      unique case (ph)
        PH_FETCH: ir <= mem_rdata;
        PH_DEC: begin
          a_q   <= rs_val;
          b_q   <= rt_val;
          imm_q <= sext16(ir[15:0]);
        end
        PH_EXE: begin
          alu_q  <= alu_res;
          inc_q  <= pc_inc;
          tgt_q  <= pc_tgt;
          take_q <= (kind == K_BNE) && differ;
        end
        PH_MEM: if (kind == K_LW) mdr_q <= mem_rdata;
        PH_WB:  pc <= take_q ? tgt_q : inc_q;
        default: ;
      endcase
    end
  end

  assign mem_addr  = (ph == PH_MEM) ? alu_q[AW-1:0] : pc;
  assign mem_wdata = b_q;
  assign mem_we    = 1'b0;
  assign phase     = ph;

  assign wb_we   = wb_ev && (kind == K_ADD || kind == K_SUB || kind == K_LW);
  assign wb_reg  = (kind == K_LW) ? ir[16 +: RW] : ir[11 +: RW];
  assign wb_data = (kind == K_LW) ? mdr_q : alu_q;

  logic unused_bits;
  assign unused_bits = ^{alu_q[XLEN-1:AW], fetch_ev};

  // assertions
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_upd |=> $stable(pc));
  p_write_in_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (phase == 3'd4));
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_FETCH) |=> $stable(ir));
  p_fetch_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> (mem_addr == pc && !mem_we));
  p_nop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_NOP || kind == K_BNE) |-> !wb_we);
endmodule

// File: tb/mc_core_bench.sv
module mc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int MSIZE = 1 << AW;
  localparam int PEND = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata, mem_wdata, wb_data;
  logic mem_we, wb_we;
  logic [2:0] phase;
  logic [4:0] wb_reg;

  logic [31:0] mem [MSIZE];
  logic [31:0] mrf [32];
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  mc_core u_mc_core (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .phase(phase), .wb_we(wb_we),
    .wb_reg(wb_reg), .wb_data(wb_data));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] r_enc(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] i_enc(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int mpc, op_sel, rs, rt, rd;
    logic [31:0] ins, exp_d, lw_a;
    logic [5:0] op, fn;
    bit exp_we;
    int exp_reg, nxt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MSIZE; i++) mem[i] = $urandom;
    for (int i = 0; i < 32; i++) mrf[i] = '0;
    mem[900] = 32'd3; mem[901] = 32'd1;
    // directed: reset-zero read, shift ignored, loads, backward loop
    mem[0] = r_enc(10, 11, 9, 31, 6'b010000);       // add r9 = r10+r11 (0), shift set
    mem[1] = i_enc(6'b100101, 0, 1, 900);            // lw r1 <- [900] = 3
    mem[2] = i_enc(6'b100101, 0, 2, 901);            // lw r2 <- [901] = 1
    mem[3] = r_enc(1, 2, 4, 0, 6'b010010);           // sub r4 = 3-1
    mem[4] = r_enc(1, 1, 5, 7, 6'b010000);           // add r5 = 6
    mem[5] = r_enc(1, 2, 6, 0, 6'b000001);           // illegal func
    mem[6] = r_enc(1, 2, 1, 0, 6'b010010);           // loop: sub r1 = r1-1
    mem[7] = i_enc(6'b000101, 1, 3, -2);             // bne r1,r3 -> 6
    mem[8] = r_enc(3, 2, 7, 0, 6'b010010);           // sub r7 = 0-1 wrap
    mem[9] = i_enc(6'b111111, 1, 2, 5);              // illegal op
    for (int i = 10; i < 20; i++) mem[i] = i_enc(6'b100101, 0, i - 2, 600 + i);
    for (int a = 20; a < PEND; a++) begin
      op_sel = $urandom_range(0, 99);
      rs = $urandom_range(0, 31); rt = $urandom_range(0, 31); rd = $urandom_range(0, 31);
      if (op_sel < 30)      mem[a] = r_enc(rs, rt, rd, $urandom_range(0, 31), 6'b010000);
      else if (op_sel < 55) mem[a] = r_enc(rs, rt, rd, $urandom_range(0, 31), 6'b010010);
      else if (op_sel < 75) mem[a] = i_enc(6'b100101, rs, rt, $urandom_range(0, 65535));
      else if (op_sel < 90) mem[a] = i_enc(6'b000101, rs, (op_sel & 1) ? rs : rt, $urandom_range(0, 3));
      else if (op_sel < 95) mem[a] = i_enc(6'(8 + $urandom_range(0, 3)), rs, rt, 1);
      else                  mem[a] = r_enc(rs, rt, rd, 0, 6'b110011);
    end

    #(CLK_PERIOD*2 + 1);
    chk(phase == 3'd0 && mem_addr == '0, "R1", {phase, 22'(mem_addr)}, 0);
    @(negedge clk); rst_n = 1'b1;
    chk(phase == 3'd0 && mem_addr == '0, "R1", {phase, 22'(mem_addr)}, 0);
    mpc = 0;
    while (mpc < PEND) begin
      chk(phase == 3'd0, "R2", phase, 0);
      chk(mem_addr == AW'(mpc) && !mem_we, "R3", mem_addr, mpc);
      ins = mem[mpc];
      op = ins[31:26]; fn = ins[5:0];
      rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      exp_we = 0; exp_reg = 0; exp_d = 0; nxt = (mpc + 1) % MSIZE;
      lw_a = (mrf[rs] + sx(ins[15:0])) & (MSIZE - 1);
      if (op == 6'b000000 && fn == 6'b010000) begin exp_we = 1; exp_reg = rd; exp_d = mrf[rs] + mrf[rt]; end
      else if (op == 6'b000000 && fn == 6'b010010) begin exp_we = 1; exp_reg = rd; exp_d = mrf[rs] - mrf[rt]; end
      else if (op == 6'b100101) begin exp_we = 1; exp_reg = rt; exp_d = mem[lw_a]; end
      else if (op == 6'b000101 && mrf[rs] != mrf[rt])
        nxt = int'((32'(mpc + 1) + sx(ins[15:0])) & (MSIZE - 1));
      for (int p = 1; p <= 4; p++) begin
        @(negedge clk);
        chk(phase == 3'(p), "R2", phase, p);
        if (p < 4) chk(!wb_we, "R9", wb_we, 0);
        if (p == 3 && op == 6'b100101) chk(mem_addr == AW'(lw_a), "R6", mem_addr, lw_a);
        if (p < 4) chk(mem_addr == AW'(mpc) || p == 3, "R9", mem_addr, mpc);
      end
      chk(wb_we == exp_we, (op == 6'b000101) ? "R7" : (exp_we ? "R4" : "R8"), wb_we, exp_we);
      if (exp_we) begin
        chk(wb_reg == 5'(exp_reg), "R6", wb_reg, exp_reg);
        chk(wb_data == exp_d, (mpc == 0) ? "R10" : (op == 6'b100101 ? "R6" : (fn == 6'b010010 ? "R5" : "R4")),
            wb_data, exp_d);
        mrf[exp_reg] = exp_d;
      end
      @(negedge clk);
      chk(mem_addr == AW'(nxt), (op == 6'b000101) ? "R7" : "R8", mem_addr, nxt);
      mpc = nxt;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule